// File: doc/BRIEF.md
# Banked Subroutine Call/Return Sequencer

This block carries out the stack traffic for four control-flow operations: a near call, a near return, a banked call and a banked return. It holds a 16-bit program counter, a 16-bit stack pointer and an 8-bit page register. The page register chooses which 16 KB bank of a larger memory appears in the fixed window at 0x8000–0xBFFF. A one-cycle `start` with an operation code launches a sequence. The block then drives a byte-wide, single-port stack memory and commits the new register values at the end of a fixed number of cycles. `done` marks the last of those cycles.

The banked call saves a three-byte frame: the return address and, below it, the page that was active. It then switches to the page given as operand. The banked return undoes this in the opposite order. The return address pushed by either call is the current program counter, which by convention already points past the calling instruction. A combinational translator turns any 16-bit CPU address into a 22-bit physical address through the current page.

Top module: `bank_call_seq`

## Requirements
- R1: After reset, pc = 0x4000, sp = 0x3C00, page = 0x3F, busy = 0, done = 0 and no stack access is made.
- R2: op = 0 (near call) writes pc[15:8] at sp-2 in cycle 1 and pc[7:0] at sp-1 in cycle 2. done is high in cycle 4, where cycle 1 is the cycle after start is taken. After that cycle sp = sp-2 and pc = target.
- R3: op = 1 (near return) reads sp in cycle 1 and sp+1 in cycle 2, taking those as the high and low byte of the return address. done is high in cycle 5. Afterwards pc = {M[sp], M[sp+1]} and sp = sp+2.
- R4: op = 2 (banked call) writes the return address as in R2 and the old page at sp-3 in cycle 3. done is high in cycle 7. Afterwards sp = sp-3, page = page operand and pc = target.
- R5: op = 3 (banked return) reads the page at sp in cycle 1, the high address byte at sp+1 and the low byte at sp+2. done is high in cycle 7. Afterwards page, pc and sp = sp+3 are restored.
- R6: The stack port makes at most one byte access per cycle and only while busy. Read data is taken from mem_rdata one cycle after the read address is presented.
- R7: done is a single-cycle pulse in the last cycle of an operation. pc, sp and page keep their values in every other cycle.
- R8: A start that arrives while busy is ignored and does not change the result of the operation in progress.
- R9: page_err is high whenever the page register lies outside 0x30..0x3F. An out-of-range operand is still loaded by a banked call.
- R10: For cpu_addr in 0x8000..0xBFFF, phys_addr = {page, cpu_addr[13:0]}. Any other address maps to itself, zero-extended to 22 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken when not busy |
| op | input | 2 | 0 near call, 1 near return, 2 banked call, 3 banked return |
| target | input | 16 | Call destination |
| page_op | input | 8 | Page loaded by a banked call |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| page | output | 8 | Page register |
| page_err | output | 1 | Page register outside the valid range |
| mem_en | output | 1 | Stack access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after the read |
| cpu_addr | input | 16 | Address to translate |
| phys_addr | output | 22 | Translated physical address |

## Verification
The hardest situations to produce are nested frames and a page that is out of range on the stack. A banked return must recover a page that an earlier call pushed. The stimulus table therefore chains operations: a near call, two nested banked calls (the inner one loading page 0x45) and then the three matching returns. Each return reads back bytes that the bench memory model stored from the block's own writes. A second stray start is pulsed in the middle of a running call to show that it leaves no trace.

// File: rtl/bank_call_seq.sv
module bank_call_seq #(
  parameter int          OFS      = 14,
  parameter logic [7:0]  PAGE_LO  = 8'h30,
  parameter logic [7:0]  PAGE_HI  = 8'h3F,
  parameter logic [7:0]  PAGE_RST = 8'h3F,
  parameter logic [15:0] SP_RST   = 16'h3C00,
  parameter logic [15:0] PC_RST   = 16'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [15:0] target,
  input  logic [7:0]  page_op,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [7:0]  page,
  output logic        page_err,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic [15:0] cpu_addr,
  output logic [7+OFS:0] phys_addr
);
  localparam logic [1:0] NCALL = 2'd0, NRET = 2'd1, BCALL = 2'd2, BRET = 2'd3;
  localparam int PA = 8 + OFS;

  logic [1:0]  op_q;
  logic [15:0] tgt_q;
  logic [7:0]  pgop_q;
  logic [2:0]  cnt;
  logic [2:0]  last;
  logic [7:0]  rd_hi, rd_lo, rd_pg;
  logic        in_win;

  assign last = (op_q == NCALL) ? 3'd4 : (op_q == NRET) ? 3'd5 : 3'd7;
  assign done = busy && (cnt == last);
  assign page_err = (page < PAGE_LO) || (page > PAGE_HI);

  assign in_win    = (cpu_addr[15:14] == 2'b10);
  assign phys_addr = in_win ? {page, cpu_addr[OFS-1:0]} : PA'(cpu_addr);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (busy) begin
      case (op_q)
        NCALL, BCALL: begin
          if (cnt == 3'd1) begin
            mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp - 16'd2; mem_wdata = pc[15:8];
          end else if (cnt == 3'd2) begin
            mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp - 16'd1; mem_wdata = pc[7:0];
          end else if (cnt == 3'd3 && op_q == BCALL) begin
            mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp - 16'd3; mem_wdata = page;
          end
        end
        NRET: begin
          if (cnt == 3'd1) begin
            mem_en = 1'b1; mem_addr = sp;
          end else if (cnt == 3'd2) begin
            mem_en = 1'b1; mem_addr = sp + 16'd1;
          end
        end
        default: begin
          if (cnt >= 3'd1 && cnt <= 3'd3) begin
            mem_en = 1'b1; mem_addr = sp + 16'(cnt - 3'd1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_q   <= NCALL;
      tgt_q  <= '0;
      pgop_q <= '0;
      rd_hi  <= '0;
      rd_lo  <= '0;
      rd_pg  <= '0;
      pc     <= PC_RST;
      sp     <= SP_RST;
      page   <= PAGE_RST;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        cnt    <= 3'd1;
        op_q   <= op;
        tgt_q  <= target;
        pgop_q <= page_op;
      end
    end else begin
      if (op_q == NRET) begin
        if (cnt == 3'd2) rd_hi <= mem_rdata;
        if (cnt == 3'd3) rd_lo <= mem_rdata;
      end else if (op_q == BRET) begin
        if (cnt == 3'd2) rd_pg <= mem_rdata;
        if (cnt == 3'd3) rd_hi <= mem_rdata;
        if (cnt == 3'd4) rd_lo <= mem_rdata;
      end
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
        case (op_q)
          NCALL: begin sp <= sp - 16'd2; pc <= tgt_q; end
          NRET:  begin sp <= sp + 16'd2; pc <= {rd_hi, rd_lo}; end
          BCALL: begin sp <= sp - 16'd3; pc <= tgt_q; page <= pgop_q; end
          default: begin sp <= sp + 16'd3; pc <= {rd_hi, rd_lo}; page <= rd_pg; end
        endcase
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/bank_call_seq_chk.sv
module bank_call_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic [7:0]  page
);
  a_r6_access_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);
  a_r6_write_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc) && $stable(sp) && $stable(page));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en && !done);
endmodule

bind bank_call_seq bank_call_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_en(mem_en),
  .mem_we(mem_we), .pc(pc), .sp(sp), .page(page)
);

// File: tb/sim_bank_call_seq.sv
module sim_bank_call_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] target = '0, cpu_addr = '0;
  logic [7:0]  page_op = '0;
  logic busy, done, page_err, mem_en, mem_we;
  logic [15:0] pc, sp, mem_addr;
  logic [7:0]  page, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [21:0] phys_addr;
  int tests = 0, fails = 0;
  logic [7:0] mem [0:65535];

  always #10 clk = ~clk;

  bank_call_seq u0 (.clk, .rst_n, .start, .op, .target, .page_op, .busy, .done,
    .pc, .sp, .page, .page_err, .mem_en, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .cpu_addr, .phys_addr);

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op, target, page_op, exp pc, exp sp, exp page
  localparam logic [65:0] VEC [6] = '{
    {2'd0, 16'h1234, 8'h00, 16'h1234, 16'h3BFE, 8'h3F},
    {2'd2, 16'h8100, 8'h31, 16'h8100, 16'h3BFB, 8'h31},
    {2'd2, 16'h9000, 8'h45, 16'h9000, 16'h3BF8, 8'h45},
    {2'd3, 16'h0000, 8'h00, 16'h8100, 16'h3BFB, 8'h31},
    {2'd3, 16'h0000, 8'h00, 16'h1234, 16'h3BFE, 8'h3F},
    {2'd1, 16'h0000, 8'h00, 16'h4000, 16'h3C00, 8'h3F}
  };

  task automatic run_op(logic [1:0] o, logic [15:0] t, logic [7:0] p,
                        bit stray, output int cyc);
    @(negedge clk);
    op = o; target = t; page_op = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int n = 1; n <= 12; n++) begin
      if (stray && n == 2) begin op = 2'd2; page_op = 8'h50; target = 16'hDEAD; start = 1'b1; end
      else start = 1'b0;
      if (done) begin cyc = n; break; end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    chk("R7 done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 32'h4000);
    chk("R1 sp", sp, 32'h3C00);
    chk("R1 page", page, 32'h3F);
    chk("R1 idle", {29'd0, busy, done, mem_en}, 32'd0);
    rst_n = 1'b1;
    cpu_addr = 16'hBFFF;
    @(negedge clk);
    chk("R10 window at reset page", phys_addr, 32'hFFFFF);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] o;
      int exp_cyc;
      o = VEC[i][65:64];
      exp_cyc = (o == 2'd0) ? 4 : (o == 2'd1) ? 5 : 7;
      run_op(o, VEC[i][63:48], VEC[i][47:40], 1'b0, cyc);
      chk(o == 0 ? "R2 cycles" : o == 1 ? "R3 cycles" : o == 2 ? "R4 cycles" : "R5 cycles", cyc, exp_cyc);
      chk("R2-5 pc", pc, VEC[i][39:24]);
      chk("R2-5 sp", sp, VEC[i][23:8]);
      chk("R2-5 page", page, VEC[i][7:0]);
      chk("R9 page_err", page_err, (VEC[i][7:0] < 8'h30 || VEC[i][7:0] > 8'h3F));
      if (i == 1) begin
        cpu_addr = 16'h8123; #1;
        chk("R10 window", phys_addr, 32'hC4123);
        cpu_addr = 16'hC123; #1;
        chk("R10 outside", phys_addr, 32'h0C123);
      end
      if (i == 2) begin
        chk("R2 hi byte", mem[16'h3BFE], 32'h40);
        chk("R2 lo byte", mem[16'h3BFF], 32'h00);
        chk("R4 ret hi", mem[16'h3BF9], 32'h81);
        chk("R4 ret lo", mem[16'h3BFA], 32'h00);
        chk("R4 old page", mem[16'h3BF8], 32'h31);
        chk("R4 outer page", mem[16'h3BFB], 32'h3F);
      end
    end

    mem[16'h3BFB] = 8'hA5;
    run_op(2'd0, 16'h2222, 8'h00, 1'b1, cyc);
    chk("R8 cycles", cyc, 4);
    chk("R8 pc", pc, 32'h2222);
    chk("R8 sp", sp, 32'h3BFE);
    chk("R8 page", page, 32'h3F);
    chk("R8 no extra write", mem[16'h3BFB], 32'hA5);
    repeat (3) @(negedge clk);
    chk("R8 stays idle", busy, 0);
    run_op(2'd1, 16'h0000, 8'h00, 1'b0, cyc);
    chk("R3 cycles", cyc, 5);
    chk("R3 pc", pc, 32'h4000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule